// File: doc/BRIEF.md
# Timing event frame decoder

The decoder listens to a single serial timing line and recovers a stream of 32-bit frames from it. The line carries bi-phase coded bits, two half-cells per bit, and the block samples one half-cell on every clock. A quiet gap and a start marker open each frame. Thirty-two data bits follow, then one parity bit. Each good frame is split into its accelerator, type, code and payload fields. These fields are presented to the rest of the chip with a one-cycle event strobe.

Four frame types are also routed to dedicated logic. Two consecutive time-of-day frames are joined into a 32-bit seconds value. A millisecond frame advances a millisecond counter and pulses a tick. The first millisecond frame after a new second resets that counter. Telegram group frames fill the hidden half of a two-bank store. A telegram ready frame swaps the banks, so a host reading through the read port always sees one complete telegram. A frame with a coding or parity fault raises an error strobe and changes nothing else.

Top module: `tfd_top`

## Requirements
- R1: One half-cell is sampled per clock. Bit 1 is sent as high then low, and bit 0 as low then high. A frame starts when two high half-cells follow at least 3 low half-cells. The start is followed by 32 data bits, MSB first, and then one parity bit that makes the number of ones across all 33 bits even.
- R2: Every good frame, of any type, gives exactly one `evt_stb_o` pulse with these fields: accelerator = bits 31:28, type = bits 27:24, code = bits 23:16, payload = bits 15:0.
- R3: A frame fails if a bit has two equal half-cells or if its parity is wrong. A failing frame gives one `err_stb_o` pulse and no event strobe. It leaves the time-of-day value, the millisecond state and the telegram store unchanged.
- R4: A type 2 frame (upper half) may be followed, as the very next frame, by a good type 3 frame (lower half). In that case `utc_sec_o` becomes {upper payload, lower payload} and `utc_stb_o` pulses in the same cycle as the event strobe of the type 3 frame.
- R5: An unmatched half is discarded and leaves `utc_sec_o` unchanged. This covers a type 3 frame that has no type 2 frame just before it. It also covers a type 2 frame followed by any other frame, including a failing one. When two type 2 frames arrive in a row, only the second one is kept as the pending upper half.
- R6: Each good type 1 frame pulses `ms_tick_o` together with its event strobe and advances `ms_cnt_o`. The count wraps from 999 to 0.
- R7: The first type 1 frame after a `utc_stb_o` pulse sets `ms_cnt_o` to 0 instead of advancing it.
- R8: A good type 4 frame whose code is below 8 writes its payload into group <code> of the hidden bank. Codes of 8 and above are ignored. `tgm_data_o` always shows group `tgm_addr_i` of the visible bank.
- R9: A good type 5 frame swaps the banks. After the swap, reads return the groups written since the previous swap. A group not written in that time keeps the value it held in the bank that just became visible.
- R10: After reset, all strobes are low, `utc_sec_o` is 0, `ms_cnt_o` is 0 and every telegram group reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cell sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial timing line |
| tgm_addr_i | input | 3 | Telegram group to read |
| evt_stb_o | output | 1 | Good frame received |
| evt_acc_o | output | 4 | Accelerator field of last frame |
| evt_type_o | output | 4 | Type field of last frame |
| evt_code_o | output | 8 | Code field of last frame |
| evt_pay_o | output | 16 | Payload field of last frame |
| err_stb_o | output | 1 | Faulty frame received |
| utc_stb_o | output | 1 | New seconds value published |
| utc_sec_o | output | 32 | Assembled seconds value |
| ms_tick_o | output | 1 | Millisecond frame received |
| ms_cnt_o | output | 10 | Millisecond within second |
| tgm_data_o | output | 16 | Visible telegram group value |

## Verification
Two outputs fire in the same cycle when a type 3 frame completes a time-of-day pair: its event strobe and the seconds strobe. The bench counts how often these two strobes coincide and requires that count to match the number of publishes. Millisecond ticks must likewise coincide with event strobes. The bench also reads back every telegram group after each swap. Random sequences bring up stray halves, ignored group codes and corrupted frames, and each of these is compared against a reference model kept in the bench.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
    localparam int FRAME_BITS = 32;

    localparam logic [3:0] FT_MS     = 4'd1;
    localparam logic [3:0] FT_UTC_HI = 4'd2;
    localparam logic [3:0] FT_UTC_LO = 4'd3;
    localparam logic [3:0] FT_TGM    = 4'd4;
    localparam logic [3:0] FT_RDY    = 4'd5;

    typedef struct packed {
        logic [3:0]  acc;
        logic [3:0]  ftype;
        logic [7:0]  code;
        logic [15:0] pay;
    } frame_t;
endpackage

// File: rtl/tfd_rx.sv
module tfd_rx
    import tfd_pkg::*;
#(
    parameter int GAP_MIN = 3
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   line_i,
    output logic   vld_o,
    output logic   err_o,
    output frame_t frame_o
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam int QW = $clog2(GAP_MIN + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_MARK, RX_DATA} rx_st_e;

    typedef struct packed {
        rx_st_e          st;
        logic [QW-1:0]   qcnt;
        logic            half;
        logic            first;
        logic [CW-1:0]   cnt;
        logic [FRAME_BITS-1:0] sh;
        logic            par;
        logic            vld;
        logic            err;
        frame_t          frame;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (!line_i) begin
                    if (q.qcnt != QW'(GAP_MIN)) d.qcnt = q.qcnt + 1'b1;
                end else if (q.qcnt == QW'(GAP_MIN)) begin
                    d.st = RX_MARK;
                end else begin
                    d.qcnt = '0;
                end
            end
            RX_MARK: begin
                if (line_i) begin
                    d.st   = RX_DATA;
                    d.half = 1'b0;
                    d.cnt  = '0;
                    d.par  = 1'b0;
                end else begin
                    d.st   = RX_IDLE;
                    d.qcnt = QW'(1);
                end
            end
            default: begin
                if (!q.half) begin
                    d.first = line_i;
                    d.half  = 1'b1;
                end else begin
                    d.half = 1'b0;
                    if (q.first == line_i) begin
                        // coding violation: abandon the frame
                        d.err  = 1'b1;
                        d.st   = RX_IDLE;
                        d.qcnt = '0;
                    end else if (q.cnt == CW'(FRAME_BITS)) begin
                        if (q.par ^ q.first) begin
                            d.err = 1'b1;
                        end else begin
                            d.vld   = 1'b1;
                            d.frame = q.sh;
                        end
                        d.st   = RX_IDLE;
                        d.qcnt = '0;
                    end else begin
                        d.sh  = {q.sh[FRAME_BITS-2:0], q.first};
                        d.par = q.par ^ q.first;
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign vld_o   = q.vld;
    assign err_o   = q.err;
    assign frame_o = q.frame;

    AST_VLD_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(vld_o && err_o)); // R3
    AST_FRAME_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_o || err_o) |=> !(vld_o || err_o)); // R1
endmodule

// File: rtl/tfd_utc.sv
module tfd_utc
    import tfd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        vld_i,
    input  logic        err_i,
    input  frame_t      frame_i,
    output logic        utc_stb_o,
    output logic [31:0] utc_sec_o
);
    typedef struct packed {
        logic        pend;
        logic [15:0] hi;
        logic [31:0] sec;
        logic        stb;
    } utc_t;

    utc_t q, d;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (err_i) begin
            d.pend = 1'b0;
        end else if (vld_i) begin
            d.pend = 1'b0;
            if (frame_i.ftype == FT_UTC_HI) begin
                d.pend = 1'b1;
                d.hi   = frame_i.pay;
            end else if (frame_i.ftype == FT_UTC_LO && q.pend) begin
                d.sec = {q.hi, frame_i.pay};
                d.stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign utc_stb_o = q.stb;
    assign utc_sec_o = q.sec;

    AST_UTC_FROM_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        utc_stb_o |-> $past(vld_i && frame_i.ftype == FT_UTC_LO)); // R4
    AST_UTC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !utc_stb_o |-> $stable(utc_sec_o)); // R5
endmodule

// File: rtl/tfd_tgm.sv
module tfd_tgm
    import tfd_pkg::*;
#(
    parameter int NGRP = 8,   // power of two
    parameter int GW   = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    vld_i,
    input  frame_t                  frame_i,
    input  logic [$clog2(NGRP)-1:0] rd_addr_i,
    output logic [GW-1:0]           rd_data_o
);
    localparam int AW = $clog2(NGRP);

    typedef struct packed {
        logic                            live;
        logic [1:0][NGRP-1:0][GW-1:0]    bank;
    } tgm_t;

    tgm_t q, d;
    logic is_rdy;

    assign is_rdy = vld_i && frame_i.ftype == FT_RDY;

    always_comb begin
        d = q;
        if (vld_i && frame_i.ftype == FT_TGM && ({1'b0, frame_i.code} < 9'(NGRP)))
            d.bank[~q.live][frame_i.code[AW-1:0]] = frame_i.pay[GW-1:0];
        if (is_rdy)
            d.live = ~q.live;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rd_data_o = q.bank[q.live][rd_addr_i];

    AST_LIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_rdy |=> ($stable(rd_addr_i) -> $stable(rd_data_o))); // R8
    AST_SWAP_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_rdy |=> (q.live != $past(q.live))); // R9
endmodule

// File: rtl/tfd_top.sv
module tfd_top
    import tfd_pkg::*;
#(
    parameter int GAP_MIN    = 3,
    parameter int MS_PER_SEC = 1000,
    parameter int NGRP       = 8,
    parameter int GW         = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    line_i,
    input  logic [$clog2(NGRP)-1:0] tgm_addr_i,
    output logic                    evt_stb_o,
    output logic [3:0]              evt_acc_o,
    output logic [3:0]              evt_type_o,
    output logic [7:0]              evt_code_o,
    output logic [15:0]             evt_pay_o,
    output logic                    err_stb_o,
    output logic                    utc_stb_o,
    output logic [31:0]             utc_sec_o,
    output logic                    ms_tick_o,
    output logic [$clog2(MS_PER_SEC)-1:0] ms_cnt_o,
    output logic [GW-1:0]           tgm_data_o
);
    localparam int MW = $clog2(MS_PER_SEC);

    logic   rx_vld, rx_err;
    frame_t rx_frame;

    tfd_rx #(.GAP_MIN(GAP_MIN)) u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .vld_o  (rx_vld),
        .err_o  (rx_err),
        .frame_o(rx_frame)
    );

    tfd_utc u_utc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .vld_i    (rx_vld),
        .err_i    (rx_err),
        .frame_i  (rx_frame),
        .utc_stb_o(utc_stb_o),
        .utc_sec_o(utc_sec_o)
    );

    tfd_tgm #(.NGRP(NGRP), .GW(GW)) u_tgm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .vld_i    (rx_vld),
        .frame_i  (rx_frame),
        .rd_addr_i(tgm_addr_i),
        .rd_data_o(tgm_data_o)
    );

    typedef struct packed {
        logic          evt;
        frame_t        fr;
        logic          err;
        logic          tick;
        logic          sync;
        logic [MW-1:0] ms;
    } top_t;

    top_t q, d;

    always_comb begin
        d      = q;
        d.evt  = rx_vld;
        d.err  = rx_err;
        d.tick = 1'b0;
        if (rx_vld) d.fr = rx_frame;
        if (utc_stb_o) d.sync = 1'b1;
        if (rx_vld && rx_frame.ftype == FT_MS) begin
            d.tick = 1'b1;
            if (q.sync) begin
                d.ms   = '0;
                d.sync = 1'b0;
            end else if (q.ms == MW'(MS_PER_SEC - 1)) begin
                d.ms = '0;
            end else begin
                d.ms = q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign evt_stb_o  = q.evt;
    assign evt_acc_o  = q.fr.acc;
    assign evt_type_o = q.fr.ftype;
    assign evt_code_o = q.fr.code;
    assign evt_pay_o  = q.fr.pay;
    assign err_stb_o  = q.err;
    assign ms_tick_o  = q.tick;
    assign ms_cnt_o   = q.ms;

    AST_EVT_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(evt_stb_o && err_stb_o)); // R3
    AST_MS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_cnt_o < MW'(MS_PER_SEC)); // R6
    AST_TICK_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_tick_o |-> (evt_stb_o && evt_type_o == FT_MS)); // R6
    AST_UTC_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        utc_stb_o |-> (evt_stb_o && evt_type_o == FT_UTC_LO)); // R4
    AST_MS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ms_tick_o |-> $stable(ms_cnt_o)); // R7
endmodule

// File: tb/tfd_top_tb.sv
module tfd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic [2:0]  addr = '0;
    logic        evt_stb, err_stb, utc_stb, ms_tick;
    logic [3:0]  evt_acc, evt_type;
    logic [7:0]  evt_code;
    logic [15:0] evt_pay, tgm_data;
    logic [31:0] utc_sec;
    logic [9:0]  ms_cnt;

    always #4 clk = ~clk;

    tfd_top u_dut (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tgm_addr_i(addr),
        .evt_stb_o(evt_stb), .evt_acc_o(evt_acc), .evt_type_o(evt_type),
        .evt_code_o(evt_code), .evt_pay_o(evt_pay), .err_stb_o(err_stb),
        .utc_stb_o(utc_stb), .utc_sec_o(utc_sec), .ms_tick_o(ms_tick),
        .ms_cnt_o(ms_cnt), .tgm_data_o(tgm_data)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // observed strobe history
    int n_evt = 0, n_err = 0, n_utc = 0, n_utc_evt = 0, n_ms = 0, n_ms_evt = 0;
    logic [31:0] last_evt = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_stb) begin
                n_evt++;
                last_evt = {evt_acc, evt_type, evt_code, evt_pay};
            end
            if (err_stb) n_err++;
            if (utc_stb) begin
                n_utc++;
                if (evt_stb) n_utc_evt++;
            end
            if (ms_tick) begin
                n_ms++;
                if (evt_stb && evt_type == 4'd1) n_ms_evt++;
            end
        end
    end

    // reference model
    int e_evt = 0, e_err = 0, e_utc = 0, e_ms_n = 0;
    logic [31:0] e_last = '0, e_sec = '0;
    logic [9:0]  e_ms = '0;
    bit e_pend = 0, e_sync = 0, e_live = 0;
    logic [15:0] e_hi = '0;
    logic [15:0] e_bank [2][8];

    task automatic model(input logic [31:0] f, input int bad);
        logic [3:0] t;
        t = f[27:24];
        if (bad != 0) begin
            e_err++;
            e_pend = 0;
            return;
        end
        e_evt++;
        e_last = f;
        case (t)
            4'd1: begin
                e_ms_n++;
                if (e_sync) begin e_ms = 0; e_sync = 0; end
                else e_ms = (e_ms == 10'd999) ? 10'd0 : e_ms + 10'd1;
                e_pend = 0;
            end
            4'd2: begin e_pend = 1; e_hi = f[15:0]; end
            4'd3: begin
                if (e_pend) begin e_sec = {e_hi, f[15:0]}; e_utc++; e_sync = 1; end
                e_pend = 0;
            end
            4'd4: begin
                if (f[23:16] < 8) e_bank[~e_live][f[18:16]] = f[15:0];
                e_pend = 0;
            end
            4'd5: begin e_live = ~e_live; e_pend = 0; end
            default: e_pend = 0;
        endcase
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half(input logic v);
        @(negedge clk);
        line = v;
    endtask

    // bad: 0 good, 1 coding violation, 2 parity flipped
    task automatic send(input logic [31:0] f, input int bad);
        int vpos;
        logic b, par;
        vpos = int'($urandom_range(0, 31));
        par  = ^f;
        if (bad == 2) par = ~par;
        half(1'b1);
        half(1'b1);
        for (int i = 31; i >= -1; i--) begin
            b = (i >= 0) ? f[i] : par;
            if (bad == 1 && i == vpos) begin
                half(1'b1);
                half(1'b1);
            end else begin
                half(b);
                half(~b);
            end
        end
        for (int g = 0; g < 4; g++) half(1'b0);
        model(f, bad);
    endtask

    task automatic check_all(input bit full);
        chk(n_evt == e_evt, "R1 event count", n_evt, e_evt);
        chk(last_evt == e_last, "R2 event fields", last_evt, e_last);
        chk(n_err == e_err, "R3 error count", n_err, e_err);
        chk(n_utc == e_utc, "R4 utc publish count", n_utc, e_utc);
        chk(n_utc_evt == n_utc, "R4 utc with event", n_utc_evt, n_utc);
        chk(utc_sec == e_sec, "R5 utc value", utc_sec, e_sec);
        chk(n_ms == e_ms_n && n_ms_evt == n_ms, "R6 tick count", n_ms, e_ms_n);
        chk(ms_cnt == e_ms, "R7 ms count", ms_cnt, e_ms);
        if (full) begin
            for (int g = 0; g < 8; g++) begin
                @(negedge clk);
                addr = 3'(g);
                #1;
                chk(tgm_data == e_bank[e_live][g], "R9 telegram read", tgm_data,
                    e_bank[e_live][g]);
            end
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] t, input logic [7:0] c,
                                       input logic [15:0] p);
        return {4'hA, t, c, p};
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int k = 0; k < 2; k++)
            for (int g = 0; g < 8; g++) e_bank[k][g] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(!evt_stb && !err_stb && !utc_stb && !ms_tick, "R10 strobes idle", 0, 0);
        chk(utc_sec == 0 && ms_cnt == 0, "R10 counters zero", utc_sec, 0);
        check_all(1);

        // R4 pair, R5 strays
        send(mk(4'd2, 8'h00, 16'h6543), 0); check_all(0);
        send(mk(4'd3, 8'h00, 16'h2109), 0); check_all(0);
        chk(utc_sec == 32'h65432109, "R4 pair joined", utc_sec, 32'h65432109);
        send(mk(4'd3, 8'h00, 16'h1111), 0); check_all(0);
        send(mk(4'd2, 8'h00, 16'h2222), 0);
        send(mk(4'd1, 8'h00, 16'h0000), 0); check_all(0);
        send(mk(4'd3, 8'h00, 16'h3333), 0); check_all(0);
        send(mk(4'd2, 8'h00, 16'h4444), 0);
        send(mk(4'd2, 8'h00, 16'h4444), 1); check_all(0);
        send(mk(4'd3, 8'h00, 16'h5555), 0); check_all(0);
        chk(utc_sec == 32'h65432109, "R5 strays discarded", utc_sec, 32'h65432109);
        send(mk(4'd2, 8'h00, 16'h7777), 0);
        send(mk(4'd2, 8'h00, 16'h8888), 0);
        send(mk(4'd3, 8'h00, 16'h9999), 0); check_all(0);
        chk(utc_sec == 32'h88889999, "R5 second upper kept", utc_sec, 32'h88889999);

        // R8 fill hidden bank, R9 swap
        send(mk(4'd4, 8'd3, 16'hBEEF), 0); check_all(1);
        send(mk(4'd4, 8'd9, 16'hDEAD), 0); check_all(1);
        send(mk(4'd4, 8'd7, 16'h0123), 2); check_all(1);
        send(mk(4'd5, 8'd0, 16'h0000), 0); check_all(1);
        chk(tgm_data == e_bank[e_live][7], "R8 last read group", tgm_data, e_bank[e_live][7]);
        send(mk(4'd4, 8'd0, 16'hCAFE), 0);
        send(mk(4'd5, 8'd0, 16'h0000), 0); check_all(1);

        // R7 sync then R6 wrap
        send(mk(4'd2, 8'h00, 16'h0001), 0);
        send(mk(4'd3, 8'h00, 16'h0002), 0);
        send(mk(4'd1, 8'h00, 16'h0000), 0); check_all(0);
        chk(ms_cnt == 0, "R7 first ms after second", ms_cnt, 0);
        for (int i = 0; i < 1000; i++) begin
            send(mk(4'd1, 8'h00, 16'(i)), 0);
            check_all(0);
        end
        chk(ms_cnt == 0, "R6 wrap to zero", ms_cnt, 0);

        // random mix
        for (int i = 0; i < 250; i++) begin
            int r, bad;
            logic [3:0] t;
            logic [31:0] f;
            r   = int'($urandom_range(0, 99));
            bad = (r < 10) ? int'($urandom_range(1, 2)) : 0;
            t   = 4'($urandom_range(0, 8));
            f   = {4'($urandom), t, 8'($urandom_range(0, 11)), 16'($urandom)};
            send(f, bad);
            if (r >= 10 && r < 25) send(mk(4'd3, 8'h00, 16'($urandom)), 0);
            check_all(i % 10 == 0);
        end
        check_all(1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule